// File: doc/BRIEF.md
# USB Device Suspend and Wake-up Controller

This block decides when a full-speed USB device port goes into suspend and when it comes back out. It watches the decoded bus line state, the bus-power indication and the connect-enable setting. It enters suspend after an unbroken stretch of idle J-state, or after bus power is lost while connect is disabled. On entry it sets a sticky status flag, which raises an interrupt when that interrupt is enabled. It also shows firmware a live bus-idle status. Firmware can use that status to abandon a suspend entry and, at the end of the entry, to stop the internal clocks.

Timing comes from a tick that divides the system clock by `TICK_DIV`. With one tick per millisecond, the idle threshold of `IDLE_TICKS` = 3 gives the 3 ms bus-idle rule. The dwell of `DWELL_TICKS` = 5 gives the minimum of 5 ms spent in suspend before any wake-up source is honoured. Once the dwell is over, any of the following brings the device back to the awake state: resume signalling, other bus traffic, chip-select or the wake-up pin. The wake restarts the clocks, gives a one-cycle wake pulse and starts idle counting again from zero.

Top module: `usb_susp_ctrl`

## Requirements
- R1: With `conn_en`=1, the block enters suspend (`in_susp` 1 the cycle after the condition holds) once the line has been J (`line_st`=2'b01) for `IDLE_TICKS` tick pulses without a break. Any other code (SE0=2'b00, K=2'b10, 2'b11) clears the idle count to zero.
- R2: With `conn_en`=0, the block enters suspend when `vbus_ok` is 0. It never enters suspend while `vbus_ok` is 1, however long the line stays J.
- R3: `susp_flag` goes to 1 on each awake-to-suspend transition. A `stat_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R4: `irq` is 1 exactly when `susp_flag` is 1 and `irq_en` is 1.
- R5: `bus_idle` is 1 while the suspend condition of R1/R2 holds and 0 otherwise. It is live and does not depend on the suspend state.
- R6: `clk_run` is 1 after reset. It goes to 0 only when `clkrun_clr` is pulsed while suspended. A `clkrun_clr` pulse while awake has no effect.
- R7: After entry, wake sources are ignored for `DWELL_TICKS` tick pulses. They are not latched, so a source that pulses and clears inside the dwell causes no wake.
- R8: After the dwell, any of the following returns the block to awake on the next cycle: a non-J line state while `vbus_ok`=1, `cs_act`=1, or `wake_pin`=1. On that return `clk_run` goes to 1 and `wake_pulse` is high for exactly one cycle.
- R9: A resume K-state that starts during the dwell and is still present when the dwell ends causes a wake.
- R10: After a wake the idle count restarts from zero, even if the line is J, so a fresh full idle period is needed before the next suspend.
- R11: Right after reset: `in_susp`=0, `susp_flag`=0, `irq`=0, `clk_run`=1, `wake_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_st | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 invalid |
| vbus_ok | input | 1 | Bus power present |
| conn_en | input | 1 | Software connect enabled |
| cs_act | input | 1 | Chip-select asserted (wake source) |
| wake_pin | input | 1 | Dedicated wake-up input |
| irq_en | input | 1 | Suspend interrupt enable |
| stat_clr | input | 1 | Write-one-to-clear pulse for the suspend flag |
| clkrun_clr | input | 1 | Firmware command to stop the clocks |
| susp_flag | output | 1 | Sticky suspend-status flag |
| irq | output | 1 | Masked suspend interrupt |
| bus_idle | output | 1 | Live bus suspend-condition status |
| clk_run | output | 1 | Internal clock enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| in_susp | output | 1 | Block is in the suspend state |

## Verification
The bench places a single K cycle just before the idle threshold. A design that did not clear its idle count would suspend too early. It also pulses chip-select, the wake pin and K inside the dwell. A design that latched these pulses, or acted on them, would wake before the dwell ends. It holds K across the end of the dwell, where a design that only reacted to edges would never wake. After waking on chip-select with the line still J, it checks that suspend does not come back at once. That would happen if the idle count were not restarted. Finally it runs the connect-disabled case with power present and then absent, and issues clock-stop and flag-clear commands while awake and while suspended.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_BAD = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'b00,
        ST_DWELL = 2'b01,
        ST_ARMED = 2'b10
    } susp_state_e;

endpackage

// File: rtl/usb_susp_tick.sv
module usb_susp_tick #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_regs_t;

    tick_regs_t q, d;

    assign tick = (q.div == DIV_W'(TICK_DIV - 1));

    always_comb begin
        d = q;
        if (tick) d.div = '0;
        else      d.div = q.div + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: tick is a single-cycle strobe whenever the divider exceeds one
    a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (TICK_DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/usb_susp_idle.sv
module usb_susp_idle
    import usb_susp_pkg::*;
#(
    parameter int IDLE_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] line_st,
    input  logic       restart,
    output logic       idle_det
);
    localparam int IC_W = $clog2(IDLE_TICKS + 1);

    typedef struct packed {
        logic [IC_W-1:0] cnt;
    } idle_regs_t;

    idle_regs_t q, d;

    assign idle_det = (q.cnt == IC_W'(IDLE_TICKS));

    always_comb begin
        d = q;
        if (line_st != LS_J || restart)
            d.cnt = '0;
        else if (tick && !idle_det)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: a non-J line state wipes any idle progress
    a_r1_nonj_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (line_st != LS_J) |=> !idle_det);
    // R10: an accepted wake restarts idle counting
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !idle_det);
endmodule

// File: rtl/usb_susp_fsm.sv
module usb_susp_fsm
    import usb_susp_pkg::*;
#(
    parameter int DWELL_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       idle_det,
    input  logic [1:0] line_st,
    input  logic       vbus_ok,
    input  logic       conn_en,
    input  logic       cs_act,
    input  logic       wake_pin,
    input  logic       stat_clr,
    input  logic       clkrun_clr,
    output logic       wake_acc,
    output logic       bus_idle,
    output logic       susp_flag,
    output logic       clk_run,
    output logic       wake_pulse,
    output logic       in_susp
);
    localparam int DW_W = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;

    typedef struct packed {
        susp_state_e      st;
        logic [DW_W-1:0]  dwell;
        logic             flag;
        logic             clk_run;
        logic             wake_p;
    } fsm_regs_t;

    fsm_regs_t q, d;
    logic susp_cond;
    logic wake_ev;

    assign susp_cond  = conn_en ? idle_det : !vbus_ok;
    assign wake_ev    = (vbus_ok && line_st != LS_J) || cs_act || wake_pin;
    assign wake_acc   = (q.st == ST_ARMED) && wake_ev;
    assign bus_idle   = susp_cond;
    assign susp_flag  = q.flag;
    assign clk_run    = q.clk_run;
    assign wake_pulse = q.wake_p;
    assign in_susp    = (q.st != ST_AWAKE);

    always_comb begin
        d        = q;
        d.wake_p = 1'b0;
        if (stat_clr) d.flag = 1'b0;
        unique case (q.st)
            ST_AWAKE: begin
                if (susp_cond) begin
                    d.st    = ST_DWELL;
                    d.dwell = '0;
                    d.flag  = 1'b1;
                end
            end
            ST_DWELL: begin
                if (clkrun_clr) d.clk_run = 1'b0;
                if (tick) begin
                    if (q.dwell == DW_W'(DWELL_TICKS - 1)) d.st = ST_ARMED;
                    else                                   d.dwell = q.dwell + 1'b1;
                end
            end
            ST_ARMED: begin
                if (wake_acc) begin
                    d.st      = ST_AWAKE;
                    d.clk_run = 1'b1;
                    d.wake_p  = 1'b1;
                end else if (clkrun_clr) begin
                    d.clk_run = 1'b0;
                end
            end
            default: d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_AWAKE;
            q.dwell   <= '0;
            q.flag    <= 1'b0;
            q.clk_run <= 1'b1;
            q.wake_p  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R2: with connect off and power present, no suspend entry
    a_r2_no_entry_powered: assert property (@(posedge clk) disable iff (!rst_n)
        (!conn_en && vbus_ok && q.st == ST_AWAKE) |=> (q.st == ST_AWAKE));
    // R3: flag rises only together with a fresh suspend entry
    a_r3_flag_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_flag) |-> (in_susp && $past(q.st) == ST_AWAKE));
    // R6: clocks stop only on a firmware command while suspended
    a_r6_clkrun_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_run) |-> ($past(clkrun_clr) && $past(in_susp)));
    // R7: the dwell state never ends in a wake
    a_r7_dwell_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DWELL) |=> !wake_pulse);
    // R8: wake pulse lasts one cycle and comes with clocks running
    a_r8_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);
    a_r8_pulse_clkrun: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (clk_run && !in_susp));
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl #(
    parameter int TICK_DIV    = 100000,
    parameter int IDLE_TICKS  = 3,
    parameter int DWELL_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       vbus_ok,
    input  logic       conn_en,
    input  logic       cs_act,
    input  logic       wake_pin,
    input  logic       irq_en,
    input  logic       stat_clr,
    input  logic       clkrun_clr,
    output logic       susp_flag,
    output logic       irq,
    output logic       bus_idle,
    output logic       clk_run,
    output logic       wake_pulse,
    output logic       in_susp
);
    logic tick;
    logic idle_det;
    logic wake_acc;

    usb_susp_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    usb_susp_idle #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .line_st  (line_st),
        .restart  (wake_acc),
        .idle_det (idle_det)
    );

    usb_susp_fsm #(.DWELL_TICKS(DWELL_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .idle_det   (idle_det),
        .line_st    (line_st),
        .vbus_ok    (vbus_ok),
        .conn_en    (conn_en),
        .cs_act     (cs_act),
        .wake_pin   (wake_pin),
        .stat_clr   (stat_clr),
        .clkrun_clr (clkrun_clr),
        .wake_acc   (wake_acc),
        .bus_idle   (bus_idle),
        .susp_flag  (susp_flag),
        .clk_run    (clk_run),
        .wake_pulse (wake_pulse),
        .in_susp    (in_susp)
    );

    assign irq = susp_flag & irq_en;

    // R4: interrupt never fires while masked or with the flag clear
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && susp_flag));
endmodule

// File: tb/sim_usb_susp_ctrl.sv
module sim_usb_susp_ctrl;
    localparam int DIV   = 20;
    localparam int IDLE  = 3;
    localparam int DWELL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] line_st = 2'b01;
    logic vbus_ok = 1'b1, conn_en = 1'b1, cs_act = 1'b0, wake_pin = 1'b0;
    logic irq_en = 1'b1, stat_clr = 1'b0, clkrun_clr = 1'b0;
    logic susp_flag, irq, bus_idle, clk_run, wake_pulse, in_susp;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    // behavioural model state
    int m_div, m_idle, m_st, m_dwell;
    bit m_flag, m_clk, m_wp;

    always #5 clk = ~clk;

    usb_susp_ctrl #(.TICK_DIV(DIV), .IDLE_TICKS(IDLE), .DWELL_TICKS(DWELL)) u0 (
        .clk(clk), .rst_n(rst_n), .line_st(line_st), .vbus_ok(vbus_ok),
        .conn_en(conn_en), .cs_act(cs_act), .wake_pin(wake_pin), .irq_en(irq_en),
        .stat_clr(stat_clr), .clkrun_clr(clkrun_clr), .susp_flag(susp_flag),
        .irq(irq), .bus_idle(bus_idle), .clk_run(clk_run), .wake_pulse(wake_pulse),
        .in_susp(in_susp));

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    function automatic bit m_cond();
        return conn_en ? (m_idle == IDLE) : !vbus_ok;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_div = 0; m_idle = 0; m_st = 0; m_dwell = 0;
            m_flag = 0; m_clk = 1; m_wp = 0;
        end else begin
            bit tk, cond, wake;
            tk   = (m_div == DIV - 1);
            cond = m_cond();
            wake = (m_st == 2) && ((vbus_ok && line_st != 2'b01) || cs_act || wake_pin);
            m_div = tk ? 0 : m_div + 1;
            m_wp = 0;
            if (stat_clr) m_flag = 0;
            if (m_st == 0) begin
                if (cond) begin m_st = 1; m_dwell = 0; m_flag = 1; end
            end else if (m_st == 1) begin
                if (clkrun_clr) m_clk = 0;
                if (tk) begin
                    if (m_dwell == DWELL - 1) m_st = 2; else m_dwell++;
                end
            end else begin
                if (wake) begin m_st = 0; m_clk = 1; m_wp = 1; end
                else if (clkrun_clr) m_clk = 0;
            end
            if (line_st != 2'b01 || wake) m_idle = 0;
            else if (tk && m_idle < IDLE) m_idle++;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1/R2/R7 in_susp", in_susp, m_st != 0);
            chk("R3 susp_flag", susp_flag, m_flag);
            chk("R4 irq", irq, m_flag & irq_en);
            chk("R5 bus_idle", bus_idle, m_cond());
            chk("R6 clk_run", clk_run, m_clk);
            chk("R8 wake_pulse", wake_pulse, m_wp);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_clr(input bit which_stat);
        if (which_stat) stat_clr = 1'b1; else clkrun_clr = 1'b1;
        step(1);
        stat_clr = 1'b0; clkrun_clr = 1'b0;
    endtask

    task automatic wait_susp(input int limit);
        for (int i = 0; i < limit && !in_susp; i++) step(1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11: reset state
        chk("R11 in_susp", in_susp, 1'b0);
        chk("R11 flag", susp_flag, 1'b0);
        chk("R11 irq", irq, 1'b0);
        chk("R11 clk_run", clk_run, 1'b1);
        chk("R11 wake_pulse", wake_pulse, 1'b0);

        // R1: a single K just short of the threshold restarts the count
        step(DIV * 2 + 5);
        line_st = 2'b10; step(1); line_st = 2'b01;
        step(DIV * 2);
        chk("R1 no early suspend", in_susp, 1'b0);
        wait_susp(DIV * 5);
        chk("R1 suspended", in_susp, 1'b1);
        chk("R3 flag set", susp_flag, 1'b1);
        chk("R5 bus idle", bus_idle, 1'b1);

        // R7: wake sources inside the dwell are neither acted on nor latched
        cs_act = 1'b1; step(1); cs_act = 1'b0;
        wake_pin = 1'b1; step(1); wake_pin = 1'b0;
        line_st = 2'b10; step(2); line_st = 2'b01;
        step(2);
        chk("R7 still suspended", in_susp, 1'b1);
        chk("R5 bus left idle is live", bus_idle, 1'b0);
        pulse_clr(1'b0);
        chk("R6 clk stopped", clk_run, 1'b0);
        pulse_clr(1'b1);
        chk("R3 flag cleared", susp_flag, 1'b0);
        step(DIV * DWELL + 5);
        chk("R7 no latched wake", in_susp, 1'b1);

        // R8: chip-select wakes once armed; R10: idle restarts from zero
        cs_act = 1'b1; step(1); cs_act = 1'b0;
        chk("R8 awake", in_susp, 1'b0);
        chk("R8 pulse", wake_pulse, 1'b1);
        chk("R8 clk_run", clk_run, 1'b1);
        step(DIV);
        chk("R10 no immediate resuspend", in_susp, 1'b0);
        wait_susp(DIV * 5);
        chk("R10 resuspends after full idle", in_susp, 1'b1);

        // R9: K started in the dwell and held across its end wakes
        step(2);
        line_st = 2'b10;
        step(DIV * DWELL + 3);
        chk("R9 K held wakes", in_susp, 1'b0);
        line_st = 2'b01;

        // R6: clock-stop and flag clear while awake
        irq_en = 1'b0;
        pulse_clr(1'b0);
        chk("R6 ignored awake", clk_run, 1'b1);
        wait_susp(DIV * 5);
        chk("R4 masked irq", irq, 1'b0);
        irq_en = 1'b1; step(1);
        chk("R4 unmasked irq", irq, 1'b1);
        step(DIV * DWELL + 3);
        wake_pin = 1'b1; step(1); wake_pin = 1'b0;
        chk("R8 pin wake", in_susp, 1'b0);

        // R2: connect disabled
        conn_en = 1'b0;
        step(DIV * 6);
        chk("R2 no suspend with power", in_susp, 1'b0);
        vbus_ok = 1'b0; step(1);
        chk("R2 power loss suspends", in_susp, 1'b1);
        step(DIV * DWELL + 3);
        vbus_ok = 1'b1;
        line_st = 2'b00; step(1); line_st = 2'b01;
        chk("R8 traffic wakes", in_susp, 1'b0);
        step(DIV * 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule